// File: doc/BRIEF.md
# Full-Duplex Byte FIFO SPI Bypass Port

This block gives software raw, byte-level access to a serial flash device. It runs only while the mode bit `legacy_en` is high. In that mode the command, direct and indirect access paths are bypassed. Every write strobe on the data port puts the low data bits into a transmit FIFO. The address and the upper data are not used. Every read strobe returns the head of a receive FIFO and removes that entry.

A serial engine drains the transmit FIFO one byte at a time. For each bit it shifts out, it also shifts one bit in, so every byte sent places one received byte into the receive FIFO. Chip select stays asserted for as long as transmit bytes keep arriving. Software must therefore write dummy bytes to read from the device, and must drain the unwanted bytes that a pure write produces. Fill levels and three sticky error flags are visible on status outputs, so software can manage the FIFOs.

Top module: `fdx_spi_port`

## Requirements
- R1: While `legacy_en` is low, the block behaves as follows:
  - bus writes and reads have no effect and `bus_rdata` is 0;
  - both levels read 0;
  - `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: While enabled, a write strobe pushes `bus_wdata` into the transmit FIFO whatever `bus_addr` holds. Bytes go out on the wire in write order.
- R3: Each byte is shifted out most-significant bit first, using clock polarity 0 and phase 0:
  - `spi_sck` idles low;
  - `spi_mosi` is set up before the first rising edge and changes only on falling edges;
  - `spi_miso` is sampled on rising edges.
  - Each serial bit lasts 2*HALF_DIV clock cycles.
- R4: Every completed byte pushes the byte sampled from `spi_miso` into the receive FIFO. A read strobe returns the head entry on `bus_rdata` in the same cycle and pops it, in arrival order.
- R5: Chip select falls when transmit data is present and stays low across back-to-back bytes. When the FIFO runs dry, `spi_cs_n` rises exactly 2*HALF_DIV clock cycles after the final falling `spi_sck` edge.
- R6: A write that arrives while `tx_level` equals DEPTH is dropped and sets the sticky `tx_ovf`.
- R7: A received byte that completes while `rx_level` equals DEPTH is dropped and sets the sticky `rx_ovf`. Earlier entries are kept.
- R8: A read while the receive FIFO is empty returns 0, leaves `rx_level` at 0 and sets the sticky `rx_unf`.
- R9: Dropping `legacy_en` has the following effects:
  - a transfer in progress is abandoned;
  - both FIFOs are emptied;
  - all three flags are cleared;
  - `spi_cs_n` goes high by the next cycle.
  - Bytes that were queued are not sent after re-enable.
- R10: A write that lands while the engine is waiting out the chip-select hold period restarts shifting without releasing chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_en | input | 1 | Bypass mode enable; low flushes everything |
| bus_wr | input | 1 | Data port write strobe |
| bus_addr | input | AW | Data port address, not decoded |
| bus_wdata | input | DW | Data port write value |
| bus_rd | input | 1 | Data port read strobe |
| bus_rdata | output | DW | Receive FIFO head, 0 when empty or disabled |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |
| tx_level | output | LW | Transmit FIFO fill level |
| rx_level | output | LW | Receive FIFO fill level |
| tx_ovf | output | 1 | Sticky: write dropped on full transmit FIFO |
| rx_ovf | output | 1 | Sticky: received byte dropped on full receive FIFO |
| rx_unf | output | 1 | Sticky: read of empty receive FIFO |

## Verification
The bench floods the transmit FIFO at one write per cycle while the engine holds only one byte. A FIFO that accepted a push when full would corrupt its oldest entries, and a receive side that overwrote on overflow would return bytes out of order. It writes a byte during the chip-select hold window: an engine that ignored late data would pulse chip select between the two bytes. It also measures the hold time exactly, which catches an off-by-one in the gap counter. Finally it drops the enable mid-byte. A design that did not flush would resume sending stale bytes after re-enable, and the bench sees this on the wire.

// File: rtl/fdx_spi_pkg.sv
package fdx_spi_pkg;
   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_SHIFT = 2'd1,
      SH_GAP   = 2'd2
   } sh_state_t;

   function automatic int lvl_width(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/fdx_spi_fifo.sv
module fdx_spi_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 8,
   parameter int LW    = fdx_spi_pkg::lvl_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/fdx_spi_shifter.sv
module fdx_spi_shifter #(
   parameter int DW        = 8,
   parameter int HALF_DIV  = 2,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tx_avail,
   input  logic [DW-1:0] tx_data,
   output logic          tx_take,
   output logic          rx_put,
   output logic [DW-1:0] rx_data,
   output logic          sck,
   output logic          cs_n,
   output logic          mosi,
   input  logic          miso
);
   import fdx_spi_pkg::*;

   localparam int CW = $clog2(2 * HALF_DIV);
   localparam int BW = $clog2(DW);
   localparam logic [CW-1:0] HALF_END = CW'(HALF_DIV - 1);
   localparam logic [CW-1:0] GAP_END  = CW'(2 * HALF_DIV - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

   sh_state_t     state;
   logic [CW-1:0] cnt;
   logic [BW-1:0] bitc;
   logic          ph;
   logic [DW-1:0] tx_sh, rx_sh, tx_next, rx_next;
   logic          out_bit, half_done, byte_end;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign out_bit = tx_sh[0];
         assign tx_next = {1'b0, tx_sh[DW-1:1]};
         assign rx_next = {miso, rx_sh[DW-1:1]};
      end else begin : g_msb
         assign out_bit = tx_sh[DW-1];
         assign tx_next = {tx_sh[DW-2:0], 1'b0};
         assign rx_next = {rx_sh[DW-2:0], miso};
      end
   endgenerate

   assign half_done = (state == SH_SHIFT) && (cnt == HALF_END);
   assign byte_end  = en && half_done && ph && (bitc == LAST_BIT);
   assign rx_put    = byte_end;
   assign rx_data   = rx_sh;
   assign mosi      = cs_n ? 1'b0 : out_bit;
   assign tx_take   = en && tx_avail &&
                      ((state == SH_IDLE) || (state == SH_GAP) || byte_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SH_IDLE;
         cnt   <= '0;
         bitc  <= '0;
         ph    <= 1'b0;
         sck   <= 1'b0;
         cs_n  <= 1'b1;
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (!en) begin
         state <= SH_IDLE;
         cnt   <= '0;
         bitc  <= '0;
         ph    <= 1'b0;
         sck   <= 1'b0;
         cs_n  <= 1'b1;
      end else begin
         case (state)
            SH_IDLE: begin
               if (tx_avail) begin
                  tx_sh <= tx_data;
                  state <= SH_SHIFT;
                  cs_n  <= 1'b0;
                  cnt   <= '0;
                  ph    <= 1'b0;
                  bitc  <= '0;
               end
            end
            SH_SHIFT: begin
               if (cnt == HALF_END) begin
                  cnt <= '0;
                  if (!ph) begin
                     sck   <= 1'b1;
                     ph    <= 1'b1;
                     rx_sh <= rx_next;
                  end else begin
                     sck <= 1'b0;
                     ph  <= 1'b0;
                     if (bitc == LAST_BIT) begin
                        bitc <= '0;
                        if (tx_avail) tx_sh <= tx_data;
                        else          state <= SH_GAP;
                     end else begin
                        bitc  <= bitc + 1'b1;
                        tx_sh <= tx_next;
                     end
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SH_GAP: begin
               if (tx_avail) begin
                  tx_sh <= tx_data;
                  state <= SH_SHIFT;
                  cnt   <= '0;
                  ph    <= 1'b0;
                  bitc  <= '0;
               end else if (cnt == GAP_END) begin
                  state <= SH_IDLE;
                  cs_n  <= 1'b1;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fdx_spi_port.sv
module fdx_spi_port #(
   parameter int DW        = 8,
   parameter int DEPTH     = 8,
   parameter int AW        = 16,
   parameter int HALF_DIV  = 2,
   parameter bit LSB_FIRST = 1'b0,
   parameter int LW        = fdx_spi_pkg::lvl_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          legacy_en,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_rd,
   output logic [DW-1:0] bus_rdata,
   output logic          spi_sck,
   output logic          spi_cs_n,
   output logic          spi_mosi,
   input  logic          spi_miso,
   output logic [LW-1:0] tx_level,
   output logic [LW-1:0] rx_level,
   output logic          tx_ovf,
   output logic          rx_ovf,
   output logic          rx_unf
);
   generate
      if (DW < 2)       begin : g_bad_dw   $error("DW must be at least 2");       end
      if (DEPTH < 2)    begin : g_bad_dep  $error("DEPTH must be at least 2");    end
      if (HALF_DIV < 1) begin : g_bad_div  $error("HALF_DIV must be at least 1"); end
      if (AW < 1)       begin : g_bad_aw   $error("AW must be at least 1");       end
   endgenerate

   logic          addr_unused;
   logic          flush;
   logic          tx_push, tx_take, tx_full, tx_empty;
   logic [DW-1:0] tx_dout;
   logic          rx_put, rx_pop, rx_full, rx_empty;
   logic [DW-1:0] rx_din, rx_dout;

   assign addr_unused = ^bus_addr;
   assign flush       = !legacy_en;
   assign tx_push     = legacy_en && bus_wr;
   assign rx_pop      = legacy_en && bus_rd;
   assign bus_rdata   = (legacy_en && !rx_empty) ? rx_dout : '0;

   fdx_spi_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(tx_push), .din(bus_wdata),
      .pop(tx_take), .dout(tx_dout),
      .level(tx_level), .full(tx_full), .empty(tx_empty)
   );

   fdx_spi_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(rx_put), .din(rx_din),
      .pop(rx_pop), .dout(rx_dout),
      .level(rx_level), .full(rx_full), .empty(rx_empty)
   );

   fdx_spi_shifter #(.DW(DW), .HALF_DIV(HALF_DIV), .LSB_FIRST(LSB_FIRST)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(legacy_en),
      .tx_avail(!tx_empty), .tx_data(tx_dout), .tx_take(tx_take),
      .rx_put(rx_put), .rx_data(rx_din),
      .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ovf <= 1'b0;
         rx_ovf <= 1'b0;
         rx_unf <= 1'b0;
      end else if (!legacy_en) begin
         tx_ovf <= 1'b0;
         rx_ovf <= 1'b0;
         rx_unf <= 1'b0;
      end else begin
         if (bus_wr && tx_full)  tx_ovf <= 1'b1;
         if (rx_put && rx_full)  rx_ovf <= 1'b1;
         if (bus_rd && rx_empty) rx_unf <= 1'b1;
      end
   end
endmodule

// File: rtl/fdx_spi_checker.sv
module fdx_spi_checker #(
   parameter int DW    = 8,
   parameter int DEPTH = 8,
   parameter int LW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          legacy_en,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [DW-1:0] bus_rdata,
   input logic          spi_sck,
   input logic          spi_cs_n,
   input logic          spi_mosi,
   input logic [LW-1:0] tx_level,
   input logic [LW-1:0] rx_level,
   input logic          tx_ovf,
   input logic          rx_ovf,
   input logic          rx_unf
);
   AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_en |=> (spi_cs_n && tx_level == '0 && rx_level == '0 && !tx_ovf && !rx_ovf && !rx_unf)); // R9
   AST_OFF_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_en |-> (bus_rdata == '0)); // R1
   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck); // R3
   AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R3
   AST_TX_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LW'(DEPTH)); // R6
   AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && bus_wr && tx_level == LW'(DEPTH)) |=> tx_ovf); // R6
   AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && tx_ovf) |=> tx_ovf); // R6
   AST_RX_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= LW'(DEPTH)); // R7
   AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && rx_ovf) |=> rx_ovf); // R7
   AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && bus_rd && rx_level == '0) |=> rx_unf); // R8
   AST_EMPTY_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> (bus_rdata == '0)); // R8
endmodule

bind fdx_spi_port fdx_spi_checker #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_fdx_chk (
   .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
   .tx_level(tx_level), .rx_level(rx_level),
   .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
);

// File: tb/fdx_spi_port_bench.sv
module fdx_spi_port_bench;
   localparam int DW    = 8;
   localparam int DEPTH = 8;
   localparam int AW    = 16;
   localparam int HD    = 2;
   localparam int LW    = $clog2(DEPTH + 1);
   localparam int TCLK  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          legacy_en = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          spi_sck, spi_cs_n, spi_mosi;
   logic          spi_miso = 1'b0;
   logic [LW-1:0] tx_level, rx_level;
   logic          tx_ovf, rx_ovf, rx_unf;

   int n_cmp = 0;
   int n_bad = 0;

   always #(TCLK/2) clk = ~clk;

   fdx_spi_port #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .HALF_DIV(HD)) u_fdx_spi_port (
      .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .tx_level(tx_level), .rx_level(rx_level),
      .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
   );

   // device model: mode 0, MSB first, answers byte n with resp(n)
   int          slv_idx = 0;
   int          bc = 0;
   logic [7:0]  s_in = '0;
   logic [7:0]  s_out = '0;
   logic [7:0]  mosi_log [0:255];
   int          cs_rises = 0;
   longint      t_fall = 0;
   longint      t_gap = 0;

   function automatic logic [7:0] resp(input int n);
      return 8'(8'hC3 ^ (n * 37));
   endfunction

   always @(posedge spi_sck or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         bc = 0;
      end else begin
         s_in = {s_in[6:0], spi_mosi};
         bc = bc + 1;
         if (bc == 8) begin
            mosi_log[slv_idx & 255] = s_in;
            slv_idx = slv_idx + 1;
            bc = 0;
         end
      end
   end

   always @(negedge spi_cs_n or negedge spi_sck) begin
      if (!spi_cs_n) begin
         if (bc == 0) s_out = resp(slv_idx);
         else         s_out = {s_out[6:0], 1'b0};
         spi_miso = s_out[7];
      end
   end

   always @(negedge spi_sck) t_fall = $time;
   always @(posedge spi_cs_n) begin
      t_gap    = $time - t_fall;
      cs_rises = cs_rises + 1;
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(output logic [DW-1:0] d);
      @(negedge clk);
      bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_idle();
      int k = 0;
      @(negedge clk);
      while (!(spi_cs_n && tx_level == '0) && k < 3000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic t_reset_and_off();
      logic [DW-1:0] v;
      chk("R1", "cs_n after reset", spi_cs_n, 1);
      chk("R1", "sck after reset", spi_sck, 0);
      chk("R1", "levels after reset", {tx_level, rx_level}, 0);
      chk("R1", "flags after reset", {tx_ovf, rx_ovf, rx_unf}, 0);
      bus_write(16'h0040, 8'hEE);
      repeat (10) @(negedge clk);
      chk("R1", "tx_level after disabled write", tx_level, 0);
      chk("R1", "cs_n after disabled write", spi_cs_n, 1);
      bus_read(v);
      chk("R1", "rdata while disabled", v, 0);
      @(negedge clk);
      chk("R1", "rx_unf after disabled read", rx_unf, 0);
   endtask

   task automatic t_single();
      int base = slv_idx;
      int r0 = cs_rises;
      logic [DW-1:0] v;
      bus_write(16'h0123, 8'h5A);
      wait_idle();
      chk("R2", "byte on wire", mosi_log[base & 255], 8'h5A);
      chk("R5", "cs pulses for one byte", cs_rises - r0, 1);
      chk("R5", "cs hold after last sck fall (ns)", t_gap, 2 * HD * TCLK);
      chk("R4", "rx_level after one byte", rx_level, 1);
      bus_read(v);
      chk("R3", "received byte", v, resp(base));
      @(negedge clk);
      chk("R4", "rx_level after read", rx_level, 0);
   endtask

   task automatic t_burst();
      int base = slv_idx;
      int r0 = cs_rises;
      logic [DW-1:0] v;
      bus_write(16'hFFFF, 8'h81);
      bus_write(16'h0000, 8'h3E);
      bus_write(16'h7A10, 8'hC4);
      wait_idle();
      chk("R2", "burst byte 0", mosi_log[base & 255], 8'h81);
      chk("R2", "burst byte 1", mosi_log[(base + 1) & 255], 8'h3E);
      chk("R2", "burst byte 2", mosi_log[(base + 2) & 255], 8'hC4);
      chk("R5", "one cs window for burst", cs_rises - r0, 1);
      for (int i = 0; i < 3; i++) begin
         bus_read(v);
         chk("R4", "burst rx order", v, resp(base + i));
      end
   endtask

   task automatic t_gap_refill();
      int base = slv_idx;
      int r0 = cs_rises;
      logic [DW-1:0] v;
      bus_write(16'h0001, 8'h11);
      repeat (8) @(negedge spi_sck);
      bus_write(16'h0002, 8'h22);
      wait_idle();
      chk("R10", "cs kept across late write", cs_rises - r0, 1);
      chk("R10", "late byte sent", mosi_log[(base + 1) & 255], 8'h22);
      for (int i = 0; i < 2; i++) begin
         bus_read(v);
         chk("R10", "rx after refill", v, resp(base + i));
      end
   endtask

   task automatic t_flood();
      int base = slv_idx;
      logic [DW-1:0] v;
      @(negedge clk);
      for (int i = 0; i < 11; i++) begin
         bus_wr = 1'b1; bus_addr = AW'(i * 7); bus_wdata = 8'(8'h90 + i);
         @(negedge clk);
      end
      bus_wr = 1'b0;
      chk("R6", "tx_ovf after flood", tx_ovf, 1);
      wait_idle();
      chk("R6", "bytes sent from flood", slv_idx - base, 9);
      for (int i = 0; i < 9; i++)
         chk("R6", "flood wire order", mosi_log[(base + i) & 255], 8'(8'h90 + i));
      chk("R7", "rx_level capped", rx_level, DEPTH);
      chk("R7", "rx_ovf set", rx_ovf, 1);
      for (int i = 0; i < DEPTH; i++) begin
         bus_read(v);
         chk("R7", "kept rx entries", v, resp(base + i));
      end
   endtask

   task automatic t_underflow();
      logic [DW-1:0] v;
      bus_read(v);
      chk("R8", "rdata on empty read", v, 0);
      chk("R8", "rx_unf set", rx_unf, 1);
      chk("R8", "rx_level stays 0", rx_level, 0);
   endtask

   task automatic t_disable();
      int base = slv_idx;
      int lows = 0;
      logic [DW-1:0] v;
      bus_write(16'h0010, 8'hA1);
      bus_write(16'h0020, 8'hB2);
      bus_write(16'h0030, 8'hC3);
      repeat (3) @(posedge spi_sck);
      @(negedge clk);
      legacy_en = 1'b0;
      @(negedge clk);
      chk("R9", "cs_n released", spi_cs_n, 1);
      chk("R9", "sck low", spi_sck, 0);
      chk("R9", "levels flushed", {tx_level, rx_level}, 0);
      chk("R9", "flags cleared", {tx_ovf, rx_ovf, rx_unf}, 0);
      legacy_en = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (!spi_cs_n) lows++;
      end
      chk("R9", "no stale bytes after re-enable", lows, 0);
      chk("R9", "no byte completed", slv_idx - base, 0);
      bus_read(v);
      chk("R9", "rx empty after flush", v, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_and_off();
      legacy_en = 1'b1;
      t_single();
      t_burst();
      t_gap_refill();
      t_flood();
      t_underflow();
      t_disable();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule